// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block turns a controller's per-machine-cycle memory requests into the strobe pattern of a multiplexed 8-bit address/data bus. A machine cycle is twelve oscillator clocks, numbered as slots 0 to 11. The request is taken at the clock edge that ends slot 11, while `cyc_last` is high, and is then played out over the next twelve clocks.

A code fetch reads two bytes, at `addr` and at `addr+1`, using the program read strobe. A data read or data write uses its own strobe, and the address latch pulse of the second half of that cycle is dropped. The low port first carries the low address byte, which an external latch captures on the falling edge of `ale`. It then floats so the memory can drive it, or it carries the write data. The high port carries the upper address byte when the access needs it. Otherwise it shows a value supplied from outside.

An enable bit taken with the request can restrict the latch pulse. When it is set, the pulse appears only in data cycles and in code-table fetches.

Top module: `ext_bus_seq`

## Requirements
- R1: While `rst_n` is low, `ale`=0, `psen_n`=1, `rd_n`=1, `wr_n`=1, `lo_oe`=0, `rd_valid`=0 and `cyc_last`=1.
- R2: In a fetch cycle (`op`=1), `ale` is high in slots 1, 2, 7 and 8, provided it is not suppressed under R8. `lo_oe` is high with `lo_out` equal to the low byte of `addr` in slots 0 to 2. It is high with `lo_out` equal to the low byte of `addr+1` in slots 6 to 8.
- R3: In a fetch cycle, `psen_n` is low in slots 3 to 5 and 9 to 11, and `lo_oe` is low in those slots. `lo_in` is captured at the edge that ends slot 5 and at the edge that ends slot 11. `rd_valid` is high with that byte on `rdata` in slot 6 and in slot 0 of the following cycle.
- R4: In a data cycle (`op`=2 read, `op`=3 write), `ale` pulses only in slots 1 and 2, and `psen_n` stays high for the whole cycle.
- R5: In a read cycle, `rd_n` is low in slots 3 to 10 and `lo_oe` is low. `lo_in` is captured at the edge that ends slot 10, and `rd_valid` is high with that byte in slot 11.
- R6: In a write cycle, `wr_n` is low in slots 3 to 10. `lo_oe` is high with `lo_out` equal to the low address byte in slots 0 to 2, then equal to `wdata` in slots 3 to 10.
- R7: `hi_out` is the high byte of `addr` during a fetch (the high byte of `addr+1` in slots 6 to 11). It is the high byte of `addr` during a data cycle with `wide`=1, and `hi_sfr` in every other case.
- R8: With `ale_off`=1, `ale` stays low in no-access cycles (`op`=0) and in fetch cycles with `tbl`=0. It pulses as usual in data cycles and in fetch cycles with `tbl`=1.
- R9: In a no-access cycle with `ale_off`=0, `ale` still pulses in slots 1, 2, 7 and 8. No strobe falls and `lo_oe` stays low.
- R10: `cyc_last` is high only in slot 11. `op`, `tbl`, `wide`, `ale_off`, `addr` and `wdata` are sampled only at the edge that ends slot 11, so changing them in other slots has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 2 | Access kind: 0 none, 1 fetch, 2 data read, 3 data write |
| tbl | input | 1 | Fetch is a code-table read |
| wide | input | 1 | Data access uses a 16-bit address |
| ale_off | input | 1 | Restrict the latch pulse to data and code-table cycles |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write data |
| hi_sfr | input | 8 | High port value when no address is driven |
| lo_in | input | 8 | Low port input from the pads |
| cyc_last | output | 1 | Slot 11; the request is sampled at the end of it |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| lo_out | output | 8 | Low port output value |
| lo_oe | output | 1 | Low port output enable |
| hi_out | output | 8 | High port output value |
| rdata | output | 8 | Captured read byte |
| rd_valid | output | 1 | `rdata` updated this clock |

## Verification
Two functions share slot 0 of the cycle that follows a fetch: the second fetch byte comes out on `rdata`/`rd_valid`, and the low port starts driving the new cycle's address. The bench provokes this by placing data reads, data writes and fetches directly after fetches. It judges slot 0 against both the previous vector's captured byte and the new vector's address. A second overlap occurs at the slot-11 edge, where the last fetch byte is captured in the same clock as the next request is sampled. The bench drives a different `lo_in` in each half-cycle, so taking the wrong byte shows up as a miscompare.

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int HI_W   = ADDR_W - DATA_W,
  parameter int SLOTS  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op,
  input  logic              tbl,
  input  logic              wide,
  input  logic              ale_off,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [HI_W-1:0]   hi_sfr,
  input  logic [DATA_W-1:0] lo_in,
  output logic              cyc_last,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] lo_out,
  output logic              lo_oe,
  output logic [HI_W-1:0]   hi_out,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid
);
  localparam int CW   = $clog2(SLOTS);
  localparam int HALF = SLOTS / 2;
  localparam logic [CW-1:0] S_A0   = CW'(1);
  localparam logic [CW-1:0] S_A1   = CW'(2);
  localparam logic [CW-1:0] S_STR  = CW'(3);
  localparam logic [CW-1:0] S_MID  = CW'(HALF);
  localparam logic [CW-1:0] S_MA0  = CW'(HALF + 1);
  localparam logic [CW-1:0] S_MA1  = CW'(HALF + 2);
  localparam logic [CW-1:0] S_MSTR = CW'(HALF + 3);
  localparam logic [CW-1:0] S_FCAP = CW'(HALF - 1);
  localparam logic [CW-1:0] S_RCAP = CW'(SLOTS - 2);
  localparam logic [CW-1:0] S_LAST = CW'(SLOTS - 1);

  typedef enum logic [1:0] {OP_NONE, OP_FETCH, OP_RD, OP_WR} op_e;

  logic [CW-1:0]     cnt;
  op_e               op_q;
  logic              tbl_q, wide_q, aoff_q;
  logic [ADDR_W-1:0] a_q, a_nx, fa;
  logic [DATA_W-1:0] wd_q;
  logic              fetch, data, cap, addr_win, strobe_win, ale_win, ale_en;

  assign cyc_last = (cnt == S_LAST);
  assign fetch    = (op_q == OP_FETCH);
  assign data     = (op_q == OP_RD) || (op_q == OP_WR);
  assign a_nx     = a_q + ADDR_W'(1);
  assign fa       = (fetch && cnt >= S_MID) ? a_nx : a_q;

  assign ale_win  = (cnt == S_A0) || (cnt == S_A1) ||
                    (!data && (cnt == S_MA0 || cnt == S_MA1));
  assign ale_en   = !aoff_q || data || (fetch && tbl_q);
  assign ale      = ale_en && ale_win;

  assign psen_n   = !(fetch && ((cnt >= S_STR && cnt < S_MID) || cnt >= S_MSTR));

  assign strobe_win = (cnt >= S_STR) && (cnt <= S_RCAP);
  assign rd_n       = !(op_q == OP_RD && strobe_win);
  assign wr_n       = !(op_q == OP_WR && strobe_win);

  assign addr_win = (op_q != OP_NONE) &&
                    (cnt <= S_A1 || (fetch && cnt >= S_MID && cnt <= S_MA1));
  assign lo_oe    = addr_win || !wr_n;
  assign lo_out   = !wr_n ? wd_q : fa[DATA_W-1:0];
  assign hi_out   = (fetch || (data && wide_q)) ? fa[ADDR_W-1:DATA_W] : hi_sfr;

  assign cap = (fetch && (cnt == S_FCAP || cnt == S_LAST)) ||
               (op_q == OP_RD && cnt == S_RCAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= S_LAST;
      op_q     <= OP_NONE;
      tbl_q    <= 1'b0;
      wide_q   <= 1'b0;
      aoff_q   <= 1'b0;
      a_q      <= '0;
      wd_q     <= '0;
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      cnt      <= cyc_last ? '0 : cnt + CW'(1);
      rd_valid <= cap;
      if (cap) rdata <= lo_in;
      if (cyc_last) begin
        op_q   <= op_e'(op);
        tbl_q  <= tbl;
        wide_q <= wide;
        aoff_q <= ale_off;
        a_q    <= addr;
        wd_q   <= wdata;
      end
    end
  end

  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!psen_n && (!rd_n || !wr_n)) && !(!rd_n && !wr_n));

  p_ale_quiet_in_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n || !rd_n || !wr_n) |-> !ale);

  p_port_released_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n || !rd_n) |-> !lo_oe);

  p_wdata_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n)) |-> ($stable(lo_out) && lo_oe));

  p_ale_two_clocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale);

  p_cycle_marker_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_last |=> !cyc_last);

  p_valid_after_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(psen_n) || $rose(rd_n)) |-> $past(cap) || rd_valid);
endmodule

// File: tb/test_ext_bus_seq.sv
module test_ext_bus_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] op;
  logic       tbl, wide, ale_off;
  logic [15:0] addr;
  logic [7:0] wdata, hi_sfr, lo_in;
  logic       cyc_last, ale, psen_n, rd_n, wr_n, lo_oe, rd_valid;
  logic [7:0] lo_out, hi_out, rdata;

  always #4 clk = ~clk;

  ext_bus_seq i_ext_bus_seq (
    .clk(clk), .rst_n(rst_n), .op(op), .tbl(tbl), .wide(wide), .ale_off(ale_off),
    .addr(addr), .wdata(wdata), .hi_sfr(hi_sfr), .lo_in(lo_in),
    .cyc_last(cyc_last), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .lo_out(lo_out), .lo_oe(lo_oe), .hi_out(hi_out), .rdata(rdata), .rd_valid(rd_valid));

  // {op, tbl, wide, ale_off, addr, wdata, lo byte}
  localparam int NV = 11;
  localparam logic [36:0] VEC [NV] = '{
    {2'd1, 1'b0, 1'b0, 1'b0, 16'h1234, 8'h00, 8'h5A},
    {2'd2, 1'b0, 1'b1, 1'b0, 16'hBEEF, 8'h00, 8'hC3},
    {2'd3, 1'b0, 1'b1, 1'b0, 16'h4321, 8'h99, 8'h00},
    {2'd3, 1'b0, 1'b0, 1'b0, 16'h77AA, 8'h66, 8'h00},
    {2'd2, 1'b0, 1'b0, 1'b1, 16'h0102, 8'h00, 8'h3E},
    {2'd1, 1'b0, 1'b0, 1'b1, 16'h12FF, 8'h00, 8'h81},
    {2'd1, 1'b1, 1'b0, 1'b1, 16'hFFFF, 8'h00, 8'h18},
    {2'd0, 1'b0, 1'b0, 1'b0, 16'h5555, 8'h11, 8'h00},
    {2'd0, 1'b0, 1'b1, 1'b1, 16'hAAAA, 8'h22, 8'h00},
    {2'd1, 1'b0, 1'b0, 1'b0, 16'h00FF, 8'h00, 8'hE7},
    {2'd2, 1'b0, 1'b1, 1'b0, 16'h9001, 8'h00, 8'h4D}
  };

  int nvec = 0;
  int nfail = 0;
  logic [36:0] cur;
  logic [1:0]  prev_op;
  logic [7:0]  prev_lob;

  task automatic chk(input string req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [36:0] v);
    op = v[36:35]; tbl = v[34]; wide = v[33]; ale_off = v[32];
    addr = v[31:16]; wdata = v[15:8];
  endtask

  task automatic check_slot(input int s);
    logic [1:0]  e_op;
    logic        e_aoff, e_ale, e_oe, e_valid;
    logic [15:0] a, a1, fa;
    logic [7:0]  e_lo, e_hi, e_rd, la;
    string       tag;
    e_op = cur[36:35]; e_aoff = cur[32]; a = cur[31:16]; a1 = a + 16'd1;
    la = cur[7:0];
    fa = (e_op == 2'd1 && s >= 6) ? a1 : a;
    e_ale = (!e_aoff || e_op[1] || (e_op == 2'd1 && cur[34])) &&
            (s == 1 || s == 2 || (!e_op[1] && (s == 7 || s == 8)));
    tag = e_aoff ? "R8" : (e_op[1] ? "R4" : (e_op == 2'd0 ? "R9" : "R2"));
    chk(tag, "ale", 16'(ale), 16'(e_ale));
    chk(e_op == 2'd1 ? "R3" : "R4", "psen_n", 16'(psen_n),
        16'(!(e_op == 2'd1 && ((s >= 3 && s <= 5) || s >= 9))));
    chk("R5", "rd_n", 16'(rd_n), 16'(!(e_op == 2'd2 && s >= 3 && s <= 10)));
    chk("R6", "wr_n", 16'(wr_n), 16'(!(e_op == 2'd3 && s >= 3 && s <= 10)));
    e_oe = 1'b0; e_lo = 8'h00;
    if (e_op != 2'd0 && s <= 2) begin e_oe = 1'b1; e_lo = a[7:0]; end
    else if (e_op == 2'd1 && s >= 6 && s <= 8) begin e_oe = 1'b1; e_lo = a1[7:0]; end
    else if (e_op == 2'd3 && s >= 3 && s <= 10) begin e_oe = 1'b1; e_lo = cur[15:8]; end
    chk(e_op == 2'd3 ? "R6" : "R2", "lo_oe", 16'(lo_oe), 16'(e_oe));
    if (e_oe) chk(e_op == 2'd3 ? "R6" : "R2", "lo_out", 16'(lo_out), 16'(e_lo));
    e_hi = (e_op == 2'd1 || (e_op[1] && cur[33])) ? fa[15:8] : hi_sfr;
    chk("R7", "hi_out", 16'(hi_out), 16'(e_hi));
    e_valid = 1'b0; e_rd = 8'h00;
    if (s == 6 && e_op == 2'd1) begin e_valid = 1'b1; e_rd = la; end
    if (s == 11 && e_op == 2'd2) begin e_valid = 1'b1; e_rd = ~la; end
    if (s == 0 && prev_op == 2'd1) begin e_valid = 1'b1; e_rd = prev_lob; end
    chk(e_op == 2'd2 ? "R5" : "R3", "rd_valid", 16'(rd_valid), 16'(e_valid));
    if (e_valid) chk(e_op == 2'd2 ? "R5" : "R3", "rdata", 16'(rdata), 16'(e_rd));
    chk("R10", "cyc_last", 16'(cyc_last), 16'(s == 11));
  endtask

  task automatic run_cycle(input bit perturb);
    for (int s = 0; s < 12; s++) begin
      @(negedge clk);
      check_slot(s);
      if (s == 0) begin
        lo_in = cur[7:0];
        prev_op = 2'd0;
      end
      if (s == 6) lo_in = ~cur[7:0];
      if (perturb && s < 11) begin
        op = 2'(s); tbl = ~tbl; wide = ~wide; ale_off = ~ale_off;
        addr = ~addr + 16'(s); wdata = wdata ^ 8'hFF;
      end
    end
    prev_op = cur[36:35];
    prev_lob = ~cur[7:0];
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hi_sfr = 8'hA5; lo_in = 8'h00;
    prev_op = 2'd0; prev_lob = 8'h00;
    drive(37'd0);
    repeat (3) @(negedge clk);
    chk("R1", "ale", 16'(ale), 16'd0);
    chk("R1", "psen_n", 16'(psen_n), 16'd1);
    chk("R1", "rd_n", 16'(rd_n), 16'd1);
    chk("R1", "wr_n", 16'(wr_n), 16'd1);
    chk("R1", "lo_oe", 16'(lo_oe), 16'd0);
    chk("R1", "rd_valid", 16'(rd_valid), 16'd0);
    chk("R1", "cyc_last", 16'(cyc_last), 16'd1);
    cur = VEC[0];
    drive(cur);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      run_cycle(1'b0);
      if (i == 5) hi_sfr = 8'h3C;
      cur = VEC[(i + 1) % NV];
      drive(cur);
    end
    // R10: request lines churn in every non-sampling slot
    cur = {2'd1, 1'b0, 1'b0, 1'b0, 16'h2EFF, 8'h00, 8'h96};
    drive(cur);
    run_cycle(1'b1);
    cur = {2'd3, 1'b0, 1'b1, 1'b1, 16'hC0DE, 8'hA7, 8'h00};
    drive(cur);
    run_cycle(1'b1);
    cur = {2'd2, 1'b0, 1'b1, 1'b0, 16'h8000, 8'h00, 8'h2B};
    drive(cur);
    run_cycle(1'b0);
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule